// File: doc/BRIEF.md
# Accumulator and Extend-Bit Arithmetic Unit

This block holds a processor's working register: a word-wide accumulator together with a one-bit extend flag, and the arithmetic and logic stage in front of them. A control unit drives one operation strobe per cycle. The available operations are AND and ADD against a data operand, a plain transfer of that operand, a load of a narrow input character into the low part of the accumulator, complement, rotate right or rotate left through the extend bit, clear, increment, and clearing or complementing the extend bit.

The block also drives three combinational status signals: sign, zero and extend-zero. A sequencer uses them to decide conditional skips. Memory, bus selection and instruction decoding are outside the block. The word width and the character width are parameters, with defaults of 16 and 8.

Top module: `acc_unit`

## Requirements
- R1: After a synchronous active-low reset, the accumulator holds 0 and the extend bit holds 0.
- R2: The `op_add` strobe writes the low WIDTH bits of accumulator plus operand into the accumulator and writes the carry-out into the extend bit.
- R3: The `op_and` strobe writes the bitwise AND of the accumulator and the operand into the accumulator. The extend bit is unchanged.
- R4: The `op_xfer` strobe copies the operand into the accumulator. The extend bit is unchanged.
- R5: The `op_inp` strobe writes the character input into accumulator bits CWIDTH-1..0. The upper bits and the extend bit are unchanged.
- R6: The `op_cma` strobe inverts every accumulator bit. The `op_clr` strobe sets the accumulator to 0. Neither changes the extend bit.
- R7: The `op_ror` strobe shifts the accumulator right by one. The old extend bit enters the top bit, and the old bit 0 becomes the new extend bit.
- R8: The `op_rol` strobe shifts the accumulator left by one. The old extend bit enters bit 0, and the old top bit becomes the new extend bit.
- R9: The `op_inc` strobe adds one to the accumulator, wrapping from all-ones to 0. The extend bit is unchanged.
- R10: The `op_cle` strobe clears the extend bit. The `op_cme` strobe inverts it. Neither changes the accumulator.
- R11: In a cycle with no strobe asserted, the accumulator and the extend bit hold their values.
- R12: `st_sign` equals the accumulator's top bit. `st_zero` is 1 exactly when the accumulator is 0. `st_ezero` is 1 exactly when the extend bit is 0.
- R13: No more than one strobe is asserted in any cycle. Asserting two or more is a protocol error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dr_in | input | WIDTH | Data operand |
| chr_in | input | CWIDTH | Input character |
| op_and | input | 1 | AND strobe |
| op_add | input | 1 | ADD strobe |
| op_xfer | input | 1 | Transfer strobe |
| op_inp | input | 1 | Character load strobe |
| op_cma | input | 1 | Complement strobe |
| op_ror | input | 1 | Rotate right strobe |
| op_rol | input | 1 | Rotate left strobe |
| op_clr | input | 1 | Clear strobe |
| op_inc | input | 1 | Increment strobe |
| op_cle | input | 1 | Clear-extend strobe |
| op_cme | input | 1 | Complement-extend strobe |
| acc_q | output | WIDTH | Accumulator value |
| ext_q | output | 1 | Extend bit |
| st_sign | output | 1 | Sign status |
| st_zero | output | 1 | Zero status |
| st_ezero | output | 1 | Extend-zero status |

## Verification
The bench builds the block with its default parameters: a 16-bit word and an 8-bit character. With these values the 0xFFFF-to-0 wrap of increment can be reached in a single step. The ADD carry-out can be produced from chosen operands, and the boundary where the character load stops writing is bit 7. A behavioural model predicts the accumulator, the extend bit and the status outputs every cycle. The stimulus includes directed corner values and a long run of pseudo-random single-strobe and idle cycles.

// File: rtl/acc_pkg.sv
// Package acc_pkg
// Purpose: the operation code shared by the decoder and the datapath.
// Assumes: at most one strobe is active per cycle.
package acc_pkg;
    typedef enum logic [3:0] {
        OP_NONE, OP_AND, OP_ADD, OP_XFER, OP_INP, OP_CMA,
        OP_ROR, OP_ROL, OP_CLR, OP_INC, OP_CLE, OP_CME
    } acc_op_e;
endpackage

// File: rtl/acc_op_sel.sv
// Module acc_op_sel
// Purpose: turns the one-hot operation strobes into a single operation code.
// Assumes: at most one strobe is high. If several are high, the first one
//          in the list below wins; the checker flags that case separately.
module acc_op_sel
    import acc_pkg::*;
(
    input  logic    s_and,
    input  logic    s_add,
    input  logic    s_xfer,
    input  logic    s_inp,
    input  logic    s_cma,
    input  logic    s_ror,
    input  logic    s_rol,
    input  logic    s_clr,
    input  logic    s_inc,
    input  logic    s_cle,
    input  logic    s_cme,
    output acc_op_e op
);
    // Priority encoder from strobes to operation code.
    always_comb begin
        if      (s_and)  op = OP_AND;
        else if (s_add)  op = OP_ADD;
        else if (s_xfer) op = OP_XFER;
        else if (s_inp)  op = OP_INP;
        else if (s_cma)  op = OP_CMA;
        else if (s_ror)  op = OP_ROR;
        else if (s_rol)  op = OP_ROL;
        else if (s_clr)  op = OP_CLR;
        else if (s_inc)  op = OP_INC;
        else if (s_cle)  op = OP_CLE;
        else if (s_cme)  op = OP_CME;
        else             op = OP_NONE;
    end
endmodule

// File: rtl/acc_alu.sv
// Module acc_alu
// Purpose: computes the next accumulator and extend values for one operation.
// Assumes: purely combinational; the registers live in the top module.
module acc_alu
    import acc_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int CWIDTH = 8
) (
    input  acc_op_e           op,
    input  logic [WIDTH-1:0]  acc,
    input  logic              ext,
    input  logic [WIDTH-1:0]  opnd,
    input  logic [CWIDTH-1:0] chr,
    output logic [WIDTH-1:0]  acc_nx,
    output logic              ext_nx
);
    localparam int UPW = WIDTH - CWIDTH;

    logic [WIDTH:0]   sum;
    logic [WIDTH-1:0] inc_v;
    logic [WIDTH-1:0] chr_merged;

    // Full-width adder with a carry-out bit, and the incrementer.
    always_comb begin
        sum   = {1'b0, acc} + {1'b0, opnd};
        inc_v = acc + WIDTH'(1);
    end

    // Character merge: the upper bits are kept when the character is narrower.
    generate
        if (UPW > 0) begin : g_merge
            assign chr_merged = {acc[WIDTH-1:CWIDTH], chr};
        end else begin : g_full
            assign chr_merged = chr[WIDTH-1:0];
        end
    endgenerate

    // Select the next accumulator and extend values from the operation code.
    always_comb begin
        acc_nx = acc;
        ext_nx = ext;
        unique case (op)
            OP_AND:  acc_nx = acc & opnd;
            OP_ADD:  begin acc_nx = sum[WIDTH-1:0]; ext_nx = sum[WIDTH]; end
            OP_XFER: acc_nx = opnd;
            OP_INP:  acc_nx = chr_merged;
            OP_CMA:  acc_nx = ~acc;
            OP_ROR:  begin acc_nx = {ext, acc[WIDTH-1:1]}; ext_nx = acc[0]; end
            OP_ROL:  begin acc_nx = {acc[WIDTH-2:0], ext}; ext_nx = acc[WIDTH-1]; end
            OP_CLR:  acc_nx = '0;
            OP_INC:  acc_nx = inc_v;
            OP_CLE:  ext_nx = 1'b0;
            OP_CME:  ext_nx = ~ext;
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_unit.sv
// Module acc_unit
// Purpose: the accumulator and extend registers with their ALU and status outputs.
// Assumes: synchronous active-low reset, and one-hot (or idle) strobes from the control unit.
module acc_unit
    import acc_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int CWIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  dr_in,
    input  logic [CWIDTH-1:0] chr_in,
    input  logic              op_and,
    input  logic              op_add,
    input  logic              op_xfer,
    input  logic              op_inp,
    input  logic              op_cma,
    input  logic              op_ror,
    input  logic              op_rol,
    input  logic              op_clr,
    input  logic              op_inc,
    input  logic              op_cle,
    input  logic              op_cme,
    output logic [WIDTH-1:0]  acc_q,
    output logic              ext_q,
    output logic              st_sign,
    output logic              st_zero,
    output logic              st_ezero
);
    acc_op_e          op;
    logic [WIDTH-1:0] acc_nx;
    logic             ext_nx;

    acc_op_sel u_sel (
        .s_and(op_and), .s_add(op_add), .s_xfer(op_xfer), .s_inp(op_inp),
        .s_cma(op_cma), .s_ror(op_ror), .s_rol(op_rol), .s_clr(op_clr),
        .s_inc(op_inc), .s_cle(op_cle), .s_cme(op_cme), .op(op)
    );

    acc_alu #(.WIDTH(WIDTH), .CWIDTH(CWIDTH)) u_alu (
        .op(op), .acc(acc_q), .ext(ext_q), .opnd(dr_in), .chr(chr_in),
        .acc_nx(acc_nx), .ext_nx(ext_nx)
    );

    // Accumulator and extend registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ext_q <= 1'b0;
        end else begin
            acc_q <= acc_nx;
            ext_q <= ext_nx;
        end
    end

    // Status outputs taken directly from the register contents.
    always_comb begin
        st_sign  = acc_q[WIDTH-1];
        st_zero  = (acc_q == '0);
        st_ezero = ~ext_q;
    end
endmodule

// File: rtl/acc_unit_chk.sv
// Module acc_unit_chk
// Purpose: protocol and behaviour assertions for acc_unit, attached by bind.
// Assumes: the same reset and clock as the unit it checks.
module acc_unit_chk #(
    parameter int WIDTH  = 16,
    parameter int CWIDTH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WIDTH-1:0]  dr_in,
    input logic [CWIDTH-1:0] chr_in,
    input logic [10:0]       strobes,
    input logic              op_add,
    input logic              op_inp,
    input logic              op_ror,
    input logic              op_inc,
    input logic              op_cle,
    input logic [WIDTH-1:0]  acc_q,
    input logic              ext_q,
    input logic              st_zero
);
    p_one_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes == '0) |=> ($stable(acc_q) && $stable(ext_q)));

    p_add_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_add |=> ({ext_q, acc_q} == {1'b0, $past(acc_q)} + {1'b0, $past(dr_in)}));

    p_inp_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_inp |=> (acc_q[CWIDTH-1:0] == $past(chr_in) && $stable(ext_q)));

    p_ror_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_ror |=> (ext_q == $past(acc_q[0]) && acc_q[WIDTH-1] == $past(ext_q)));

    p_inc_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_inc && acc_q == '1) |=> (st_zero && $stable(ext_q)));

    p_cle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_cle |=> (!ext_q && $stable(acc_q)));

    // R1: the registers are 0 in the cycle after reset.
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0 && ext_q == 1'b0));
endmodule

bind acc_unit acc_unit_chk #(.WIDTH(WIDTH), .CWIDTH(CWIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .dr_in(dr_in), .chr_in(chr_in),
    .strobes({op_and, op_add, op_xfer, op_inp, op_cma, op_ror, op_rol,
              op_clr, op_inc, op_cle, op_cme}),
    .op_add(op_add), .op_inp(op_inp), .op_ror(op_ror), .op_inc(op_inc),
    .op_cle(op_cle), .acc_q(acc_q), .ext_q(ext_q), .st_zero(st_zero)
);

// File: tb/acc_unit_tb_top.sv
module acc_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] dr_in = '0;
    logic [7:0]  chr_in = '0;
    logic [10:0] stb = '0;
    logic [15:0] acc_q;
    logic        ext_q, st_sign, st_zero, st_ezero;

    int checks = 0;
    int errors = 0;
    int m_acc = 0;
    int m_e = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Strobe index: 10 and, 9 add, 8 xfer, 7 inp, 6 cma, 5 ror, 4 rol, 3 clr, 2 inc, 1 cle, 0 cme
    acc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .dr_in(dr_in), .chr_in(chr_in),
        .op_and(stb[10]), .op_add(stb[9]), .op_xfer(stb[8]), .op_inp(stb[7]),
        .op_cma(stb[6]), .op_ror(stb[5]), .op_rol(stb[4]), .op_clr(stb[3]),
        .op_inc(stb[2]), .op_cle(stb[1]), .op_cme(stb[0]),
        .acc_q(acc_q), .ext_q(ext_q), .st_sign(st_sign), .st_zero(st_zero),
        .st_ezero(st_ezero)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural model: advance one cycle for strobe index k (-1 means idle).
    task automatic model(input int k, input int d, input int c);
        int s;
        case (k)
            10: m_acc = m_acc & d;
            9:  begin s = m_acc + d; m_acc = s % 65536; m_e = s / 65536; end
            8:  m_acc = d;
            7:  m_acc = (m_acc / 256) * 256 + c;
            6:  m_acc = 65535 - m_acc;
            5:  begin s = m_acc % 2; m_acc = m_acc / 2 + m_e * 32768; m_e = s; end
            4:  begin s = m_acc / 32768; m_acc = (m_acc * 2) % 65536 + m_e; m_e = s; end
            3:  m_acc = 0;
            2:  m_acc = (m_acc + 1) % 65536;
            1:  m_e = 0;
            0:  m_e = 1 - m_e;
            default: ;
        endcase
    endtask

    // Apply one operation, clock it in, then compare at the falling edge.
    task automatic step(input string req, input int k, input int d, input int c);
        dr_in = 16'(d);
        chr_in = 8'(c);
        stb = (k >= 0) ? (11'd1 << k) : '0;
        @(posedge clk);
        #1 stb = '0;
        model(k, d, c);
        @(negedge clk);
        chk(req, acc_q, m_acc);
        chk(req, ext_q, m_e);
        chk("R12 sign", st_sign, m_acc / 32768);
        chk("R12 zero", st_zero, m_acc == 0);
        chk("R12 ezero", st_ezero, m_e == 0);
    endtask

    initial begin
        int seed = 7;
        int r;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 acc", acc_q, 0);
        chk("R1 ext", ext_q, 0);
        chk("R12 ezero at reset", st_ezero, 1);
        step("R4 xfer", 8, 'h8001, 0);
        step("R3 and", 10, 'hF00F, 0);
        step("R2 add carry", 9, 'h7FFF, 0);
        step("R2 add nocarry", 9, 'h0001, 0);
        step("R6 cma", 6, 0, 0);
        step("R5 inp", 7, 0, 'hA5);
        step("R8 rol", 4, 0, 0);
        step("R7 ror", 5, 0, 0);
        step("R10 cme", 0, 0, 0);
        step("R7 ror e-in", 5, 0, 0);
        step("R10 cle", 1, 0, 0);
        step("R11 idle", -1, 'h1234, 'h56);
        step("R4 xfer ones", 8, 'hFFFF, 0);
        step("R10 cme", 0, 0, 0);
        step("R9 inc wrap", 2, 0, 0);
        step("R6 clr", 3, 'hFFFF, 0);
        step("R9 inc", 2, 0, 0);
        for (int i = 0; i < 400; i++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            r = (seed >> 8) % 12;
            step("R2-mix random", (r == 11) ? -1 : r, (seed >> 3) & 16'hFFFF, (seed >> 11) & 8'hFF);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule